// File: doc/BRIEF.md
# Keyed-Clear Watchdog Timer

This block is a watchdog counter that advances on ticks of a low-speed clock and is serviced through a single 8-bit control register on a simple register bus. Software proves it is alive by writing two key bytes in the right order. A hidden one-bit pointer selects which key the block expects next, and every accepted write flips it, whatever the data. Reading the register shows the pointer, so software can tell which key to send next.

If the counter wraps from all ones to zero, the block pulses an interrupt and enters a short blocking window that lasts until the next falling edge of the low-speed clock (half a low-speed period). During the window the counter and pointer stay at their initial values and every register write is dropped. If the counter wraps a second time with no successful clear since the first wrap, the block pulses a reset request instead. A completed clear makes the next wrap a first wrap again.

The low-speed clock reaches the block as two single-cycle pulses in the system clock domain, one for each rising edge and one for each falling edge.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the pointer reads 0, and irq_o, rst_req_o and hold_o are all low.
- R2: Each accepted write (wr_en_i and wr_byte_i high, hold_o low) inverts the pointer, whatever the value of wr_data_i.
- R3: A clear happens only when 0x5A is written while the pointer is 0 and the very next accepted write is 0xA5 with the pointer at 1. The clear is applied at the next ls_rise_i tick, which sets the counter to 0 instead of advancing it. With counter width W, the wrap then comes on the (2^W + 1)-th tick after the clear pair.
- R4: A key written against the wrong pointer value (0xA5 with the pointer at 0, or 0x5A with the pointer at 1), or any other write placed between the two keys, gives no clear, but the pointer still toggles.
- R5: With rd_en_i high, rd_data_o shows the pointer in bit 0 and zeros in bits 7 to 1. With rd_en_i low, rd_data_o is 0x00.
- R6: A write with wr_byte_i low is ignored and leaves the pointer unchanged.
- R7: The counter advances by one on each ls_rise_i tick outside the blocking window. A wrap from all ones to zero forces the pointer to 0.
- R8: On the first wrap, irq_o is high for exactly one cycle and hold_o rises. hold_o stays high until the next ls_fall_i tick. Writes made while hold_o is high are dropped and do not toggle the pointer.
- R9: A second wrap with no successful clear since the first gives a one-cycle pulse on rst_req_o and no pulse on irq_o. irq_o and rst_req_o are never high together.
- R10: After a successful clear, the next wrap is treated as a first wrap again and raises irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ls_rise_i | input | 1 | One-cycle pulse on each rising edge of the low-speed clock |
| ls_fall_i | input | 1 | One-cycle pulse on each falling edge of the low-speed clock |
| wr_en_i | input | 1 | Register write strobe |
| wr_byte_i | input | 1 | High when the access is byte-wide |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_data_o | output | 8 | Read data: pointer in bit 0 |
| irq_o | output | 1 | One-cycle pulse on the first wrap |
| rst_req_o | output | 1 | One-cycle pulse on the second wrap |
| hold_o | output | 1 | High during the blocking window after the first wrap |

## Verification
The clear sequence is driven with directed patterns and with random sequences of four writes. Each write is 0x5A, 0xA5 or an arbitrary byte, and some writes are not byte-wide. Whether a clear happened is read from the number of ticks to the next wrap: 17 ticks after a valid pair, and 16 minus the tick count before the writes when no clear happened. This separates a true clear from key pairs with the wrong pointer, from pairs broken by another write, and from ignored wide accesses. Directed runs cover the first wrap, writes placed inside the blocking window, a second wrap without a clear, and a clear after a reset request.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;
  localparam int REG_W = 8;
  localparam logic [REG_W-1:0] KEY_LEAD  = 8'h5A;
  localparam logic [REG_W-1:0] KEY_TRAIL = 8'hA5;
endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_keyed_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic             wr_byte_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             hold_i,
  input  logic             ovf_i,
  input  logic             take_i,
  output logic             ptr_o,
  output logic             pend_o
);
  logic ptr_q, ptr_d, arm_q, arm_d, pend_q, pend_d, wr_ok;

  assign wr_ok = wr_en_i & wr_byte_i & ~hold_i;

  always_comb begin
    ptr_d  = ptr_q;
    arm_d  = arm_q;
    pend_d = pend_q;
    if (take_i) pend_d = 1'b0;
    if (ovf_i) begin
      ptr_d = 1'b0;
      arm_d = 1'b0;
    end else if (wr_ok) begin
      ptr_d = ~ptr_q;
      if (!ptr_q) begin
        arm_d = (wr_data_i == KEY_LEAD);
      end else begin
        if (arm_q && (wr_data_i == KEY_TRAIL)) pend_d = 1'b1;
        arm_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= 1'b0;
      arm_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      arm_q  <= arm_d;
      pend_q <= pend_d;
    end
  end

  assign ptr_o  = ptr_q;
  assign pend_o = pend_q;

  AST_PTR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_byte_i && !hold_i && !ovf_i) |=> (ptr_q != $past(ptr_q))); // R2
  AST_WIDE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wr_byte_i && !ovf_i) |=> $stable(ptr_q)); // R6
  AST_HOLD_PTR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |-> !ptr_q); // R8
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int CNT_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic hold_i,
  input  logic clr_i,
  output logic ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign ovf_o = tick_i & ~hold_i & ~clr_i & (cnt_q == CNT_MAX);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) cnt_d = '0;
    else if (tick_i && !hold_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !hold_i && !clr_i) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R7
  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !clr_i) |=> $stable(cnt_q)); // R8
endmodule

// File: rtl/wdt_ovf_ctl.sv
module wdt_ovf_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_i,
  input  logic clr_i,
  input  logic fall_i,
  output logic irq_o,
  output logic rst_req_o,
  output logic hold_o
);
  logic first_q, first_d, hold_q, hold_d, irq_q, irq_d, req_q, req_d;

  always_comb begin
    first_d = first_q;
    hold_d  = hold_q;
    irq_d   = ovf_i & ~first_q;
    req_d   = ovf_i & first_q;
    if (clr_i)      first_d = 1'b0;
    else if (ovf_i) first_d = 1'b1;
    if (ovf_i && !first_q) hold_d = 1'b1;
    else if (fall_i)       hold_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b0;
      hold_q  <= 1'b0;
      irq_q   <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      first_q <= first_d;
      hold_q  <= hold_d;
      irq_q   <= irq_d;
      req_q   <= req_d;
    end
  end

  assign irq_o     = irq_q;
  assign rst_req_o = req_q;
  assign hold_o    = hold_q;

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q); // R8
  AST_SECOND_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_i && first_q) |=> (req_q && !irq_q)); // R9
  AST_EVENT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_q, req_q})); // R9
  AST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !first_q); // R10
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_keyed_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ls_rise_i,
  input  logic             ls_fall_i,
  input  logic             wr_en_i,
  input  logic             wr_byte_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             rd_en_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             irq_o,
  output logic             rst_req_o,
  output logic             hold_o
);
  logic ptr, pend, take, ovf, hold;

  assign take = pend & ls_rise_i;

  wdt_key_seq u_key (
    .clk, .rst_n, .wr_en_i, .wr_byte_i, .wr_data_i,
    .hold_i(hold), .ovf_i(ovf), .take_i(take),
    .ptr_o(ptr), .pend_o(pend)
  );

  wdt_count #(.CNT_W(CNT_W)) u_cnt (
    .clk, .rst_n, .tick_i(ls_rise_i), .hold_i(hold), .clr_i(take), .ovf_o(ovf)
  );

  wdt_ovf_ctl u_ctl (
    .clk, .rst_n, .ovf_i(ovf), .clr_i(take), .fall_i(ls_fall_i),
    .irq_o, .rst_req_o, .hold_o(hold)
  );

  assign hold_o    = hold;
  assign rd_data_o = rd_en_i ? {{(REG_W-1){1'b0}}, ptr} : '0;

  AST_WRAP_PTR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> !ptr); // R7
endmodule

// File: tb/wdt_keyed_tb_top.sv
module wdt_keyed_tb_top;
  localparam int CLK_P = 10;
  localparam int CW    = 4;
  localparam int WRAP  = 1 << CW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ls_rise = 0, ls_fall = 0, wr_en = 0, wr_byte = 0, rd_en = 0;
  logic [7:0] wr_data = '0, rd_data;
  logic irq, rst_req, hold;
  int errors = 0, checks = 0;
  bit ptr_m, arm_m, clr_m;

  always #(CLK_P/2) clk = ~clk;

  wdt_keyed #(.CNT_W(CW)) dut_i (
    .clk, .rst_n, .ls_rise_i(ls_rise), .ls_fall_i(ls_fall),
    .wr_en_i(wr_en), .wr_byte_i(wr_byte), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_data_o(rd_data),
    .irq_o(irq), .rst_req_o(rst_req), .hold_o(hold)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(); @(posedge clk); @(negedge clk); endtask

  task automatic do_rst();
    rst_n = 1'b0; cyc(); rst_n = 1'b1; cyc();
    ptr_m = 0; arm_m = 0; clr_m = 0;
  endtask

  // expected effect of one write on the pointer and the key sequence
  function automatic void model_wr(input logic [7:0] d, input bit b);
    if (!b) return;
    if (!ptr_m) arm_m = (d == 8'h5A);
    else begin
      if (arm_m && d == 8'hA5) clr_m = 1;
      arm_m = 0;
    end
    ptr_m = ~ptr_m;
  endfunction

  task automatic wr(input logic [7:0] d, input bit b);
    wr_en = 1; wr_byte = b; wr_data = d; cyc();
    wr_en = 0; wr_byte = 0;
  endtask

  task automatic rd_chk(input string req);
    rd_en = 1; #1;
    chk(req, int'(rd_data), int'({7'b0, ptr_m}));
    rd_en = 0;
  endtask

  task automatic rise(output bit gi, output bit gr);
    ls_rise = 1; cyc(); ls_rise = 0;
    gi = irq; gr = rst_req; cyc();
  endtask

  task automatic fall(); ls_fall = 1; cyc(); ls_fall = 0; cyc(); endtask

  task automatic to_event(input int lim, output int n, output bit gi, output bit gr);
    n = 0; gi = 0; gr = 0;
    while (n < lim) begin
      n++;
      rise(gi, gr);
      if (gi || gr) return;
      fall();
    end
  endtask

  initial begin
    int n; bit gi, gr; int seed;
    seed = $urandom(1234);
    do_rst();
    // R1 reset state
    rd_chk("R1 ptr");
    chk("R1 irq", irq, 0); chk("R1 rst_req", rst_req, 0); chk("R1 hold", hold, 0);
    #1; chk("R5 idle read", int'(rd_data), 0);
    // R2 any data toggles
    wr(8'h33, 1); model_wr(8'h33, 1); rd_chk("R2 toggle");
    wr(8'h00, 1); model_wr(8'h00, 1); rd_chk("R2 toggle back");
    // R6 wide write ignored
    wr(8'h5A, 0); model_wr(8'h5A, 0); rd_chk("R6 wide write");
    // R4 keys against the wrong pointer
    wr(8'hA5, 1); model_wr(8'hA5, 1); rd_chk("R4 ptr");
    wr(8'h5A, 1); model_wr(8'h5A, 1); rd_chk("R4 ptr");
    to_event(40, n, gi, gr);
    chk("R4 no clear ticks", n, WRAP); chk("R8 irq", gi, 1); chk("R8 no rst", gr, 0);
    ptr_m = 0;
    chk("R8 hold up", hold, 1); chk("R8 irq one cycle", irq, 0);
    wr(8'h5A, 1); rd_chk("R8 write dropped");
    wr(8'h77, 1); rd_chk("R8 write dropped");
    fall(); chk("R8 hold down", hold, 0);
    // R7 ptr forced to 0 by wrap
    wr(8'h11, 1); model_wr(8'h11, 1); rd_chk("R7 ptr set");
    to_event(40, n, gi, gr);
    ptr_m = 0; arm_m = 0;
    chk("R9 ticks", n, WRAP); chk("R9 rst_req", gr, 1); chk("R9 no irq", gi, 0);
    rd_chk("R7 ptr cleared by wrap");
    fall();
    // R3/R10 clear after reset request re-arms
    wr(8'h5A, 1); model_wr(8'h5A, 1);
    wr(8'hA5, 1); model_wr(8'hA5, 1); rd_chk("R3 ptr");
    to_event(40, n, gi, gr);
    chk("R3 clear ticks", n, WRAP + 1); chk("R10 irq again", gi, 1); chk("R10 no rst", gr, 0);
    fall();
    // random trials: R2 R3 R4 R6
    for (int t = 0; t < 12; t++) begin
      int pre, expn;
      do_rst();
      pre = 1 + int'($urandom % 10);
      for (int k = 0; k < pre; k++) begin
        rise(gi, gr); chk("R7 no early wrap", int'(gi | gr), 0); fall();
      end
      for (int k = 0; k < 4; k++) begin
        logic [7:0] d; bit b; int c;
        c = int'($urandom % 4);
        d = (c == 1) ? 8'hA5 : (c == 2) ? 8'($urandom) : 8'h5A;
        b = ($urandom % 5) != 0;
        wr(d, b); model_wr(d, b); rd_chk("R2 random ptr");
      end
      expn = clr_m ? WRAP + 1 : WRAP - pre;
      to_event(40, n, gi, gr);
      chk(clr_m ? "R3 random clear" : "R4 random no clear", n, expn);
      chk("R8 random irq", gi, 1);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule